// File: doc/BRIEF.md
# Directional Segmented Tile Mesh Router

The block is a rectangular array of small two-plane logic tiles. The tiles are joined only by vertical channels made of one-way wire groups. Each tile's routing outputs are wire groups that it alone drives. One group heads up the channel and one heads down, and each group reaches the input planes of the next two tiles in that direction. No horizontal channel exists. A signal moves sideways by entering a tile's input plane and leaving through that tile's output groups, which sit on the opposite side. Rows alternate the side their inputs face, so even rows carry traffic rightward and odd rows carry it leftward. A route longer than one segment is picked up and driven again by an intermediate tile.

Every tile computes product terms as the NOR of the inputs it selects. Each output wire is the OR of the product terms it selects, with an optional inversion. The product-term stage latches on phase A and the output stage latches on phase B. All tiles share these phases, so a signal advances one tile per full A-then-B period. External inputs enter at the array edge, where each one drives every wire of a tile's edge slot. Each external output combines a whole wire group that has been programmed identically. All tile configuration words are loaded through one serial chain that runs in row-major order.

Top module: `seg_mesh_router`

## Requirements
- R1: While `rst` is high, all configuration, product-term and output state is cleared, so `edgeOut` is 0 and `cfgDout` is 0.
- R2: With `cfgShift` high, the chain shifts one bit per clock, and the chain holds while `cfgShift` is low. `cfgDin` enters the most significant bit of tile 0. Tiles are numbered t = row*COLS + col, and each tile's bit 0 feeds the next tile's most significant bit. `cfgDout` is bit 0 of the last tile. The chain is ROWS*COLS*TB bits long.
- R3: Tile word layout, with NI = 6*W, NO = 3*W and TB = P*NI + NO*P + NO. Bit p*NI+i selects input i into product term p, and product term p is the NOR of its selected inputs (1 if none is selected). Bit P*NI+o*P+p selects product term p into output o. Bit P*NI+NO*P+o inverts output o. Outputs 0..W-1 form the up group, W..2W-1 the down group and 2W..3W-1 the feedback group.
- R4: Product terms latch only in a clock with `phaseA` high and `phaseB` low, and outputs latch only in a clock with `phaseB` high and `phaseA` low. When both phases are high, when neither is high, or when `cfgShift` is high, no tile state changes.
- R5: Within its channel, a tile's up group reaches the tiles in rows r-1 and r-2, and its down group reaches the tiles in rows r+1 and r+2. A tile's input index i is divided into slots. Slot i/W = 0 takes the up group from row r+1 and slot 1 the up group from row r+2. Slot 2 takes the down group from row r-1 and slot 3 the down group from row r-2. Slot 4 is the tile's own feedback group and slot 5 is the edge slot. Wire i%W is taken within each slot.
- R6: The tile in an even row at column c reads channel c and drives channel c+1. The tile in an odd row at column c reads channel c+1 and drives channel c.
- R7: A slot whose source tile lies outside the array reads 0.
- R8: `edgeIn[r]` drives all W wires of the edge slot of the row's input-edge tile: column 0 in even rows, column COLS-1 in odd rows. Every other tile's edge slot reads 0.
- R9: `edgeOut[r]` is the OR of the down-group wires of the row's output-edge tile: column COLS-1 in even rows, column 0 in odd rows.
- R10: A signal crosses one tile per full A-then-B period. A tile's feedback group returns to its own slot 4 in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgShift | input | 1 | Shifts the configuration chain by one bit |
| cfgDin | input | 1 | Serial configuration data in |
| cfgDout | output | 1 | Serial configuration data out, bit 0 of the last tile |
| phaseA | input | 1 | Product-term latch phase |
| phaseB | input | 1 | Output latch phase |
| edgeIn | input | ROWS | One external input per row |
| edgeOut | output | ROWS | One external output per row |

## Verification
The assertions assume that `rst` is held high through the first clock edge. They also assume that the inputs change only between clock edges, so each clock sees exactly one phase pattern. Given those assumptions, they check that the outputs change only after a clock with phase B alone and that the chain is still when not shifting. The stimulus applies every input on the falling edge and starts under reset. It deliberately mixes overlapping, absent and shift-coincident phases into the random traffic, because the design defines these patterns as having no effect.

// File: rtl/seg_mesh_pkg.sv
package seg_mesh_pkg;
  typedef struct packed {
    logic shift;
    logic evalIn;
    logic evalOut;
  } strobe_t;
endpackage

// File: rtl/seg_mesh_ctrl.sv
module seg_mesh_ctrl
  import seg_mesh_pkg::*;
(
  input  logic    cfgShift,
  input  logic    phaseA,
  input  logic    phaseB,
  output strobe_t stb
);
  // Exactly one phase and no shifting are needed for evaluation.
  always_comb begin
    stb.shift   = cfgShift;
    stb.evalIn  = phaseA & ~phaseB & ~cfgShift;
    stb.evalOut = phaseB & ~phaseA & ~cfgShift;
  end
endmodule

// File: rtl/seg_mesh_tile.sv
module seg_mesh_tile
  import seg_mesh_pkg::*;
#(
  parameter int W = 2,
  parameter int P = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  strobe_t        stb,
  input  logic           cfgIn,
  output logic           cfgOut,
  input  logic [6*W-1:0] inVec,
  output logic [3*W-1:0] outVec
);
  localparam int NI      = 6 * W;
  localparam int NO      = 3 * W;
  localparam int OR_BASE = P * NI;
  localparam int INV_BASE = OR_BASE + NO * P;
  localparam int TB      = INV_BASE + NO;

  logic [TB-1:0] cfgReg;
  logic [P-1:0]  ptNext, ptReg;
  logic [NO-1:0] outNext, outReg;

  always_ff @(posedge clk) begin
    if (rst) cfgReg <= '0;
    else if (stb.shift) cfgReg <= {cfgIn, cfgReg[TB-1:1]};
  end
  assign cfgOut = cfgReg[0];

  // Input plane: NOR of the selected wires.
  for (genvar p = 0; p < P; p++) begin : g_pterm
    assign ptNext[p] = ~|(inVec & cfgReg[p*NI +: NI]);
  end

  // Output plane: OR of the selected product terms, with polarity choice.
  for (genvar o = 0; o < NO; o++) begin : g_out
    assign outNext[o] = (|(ptReg & cfgReg[OR_BASE + o*P +: P])) ^ cfgReg[INV_BASE + o];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptReg  <= '0;
      outReg <= '0;
    end else begin
      if (stb.evalIn)  ptReg  <= ptNext;
      if (stb.evalOut) outReg <= outNext;
    end
  end
  assign outVec = outReg;
endmodule

// File: rtl/seg_mesh_fabric.sv
module seg_mesh_fabric
  import seg_mesh_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 2,
  parameter int W    = 2,
  parameter int P    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  strobe_t         stb,
  input  logic            cfgIn,
  output logic            cfgOut,
  input  logic [ROWS-1:0] edgeIn,
  output logic [ROWS-1:0] edgeOut
);
  localparam int NI = 6 * W;
  localparam int NO = 3 * W;
  localparam int NT = ROWS * COLS;

  logic [NO-1:0] tileOut [ROWS][COLS];
  logic [NT:0]   cfgLink;

  assign cfgLink[0] = cfgIn;
  assign cfgOut     = cfgLink[NT];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int  CH  = (r % 2 == 0) ? c : c + 1;
      localparam bit  EIN = (r % 2 == 0) ? (c == 0) : (c == COLS - 1);
      logic [NI-1:0] inVec;

      // Slots 0..3: segments arriving in the channel this tile reads.
      for (genvar g = 0; g < 4; g++) begin : g_slot
        localparam int SR = (g == 0) ? r + 1 : (g == 1) ? r + 2 : (g == 2) ? r - 1 : r - 2;
        localparam int SC = (((SR % 2) + 2) % 2 == 0) ? CH - 1 : CH;
        localparam bit LIVE = (SR >= 0) && (SR < ROWS) && (SC >= 0) && (SC < COLS);
        if (LIVE && g < 2) begin : g_up
          assign inVec[g*W +: W] = tileOut[SR][SC][W-1:0];
        end else if (LIVE) begin : g_dn
          assign inVec[g*W +: W] = tileOut[SR][SC][2*W-1:W];
        end else begin : g_tie
          assign inVec[g*W +: W] = '0;
        end
      end

      assign inVec[4*W +: W] = tileOut[r][c][3*W-1:2*W];
      if (EIN) begin : g_edge
        assign inVec[5*W +: W] = {W{edgeIn[r]}};
      end else begin : g_noedge
        assign inVec[5*W +: W] = '0;
      end

      seg_mesh_tile #(.W(W), .P(P)) u_tile (
        .clk   (clk),
        .rst   (rst),
        .stb   (stb),
        .cfgIn (cfgLink[r*COLS + c]),
        .cfgOut(cfgLink[r*COLS + c + 1]),
        .inVec (inVec),
        .outVec(tileOut[r][c])
      );
    end

    localparam int EC = (r % 2 == 0) ? COLS - 1 : 0;
    assign edgeOut[r] = |tileOut[r][EC][2*W-1:W];
  end
endmodule

// File: rtl/seg_mesh_router.sv
module seg_mesh_router
  import seg_mesh_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 2,
  parameter int W    = 2,
  parameter int P    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfgShift,
  input  logic            cfgDin,
  output logic            cfgDout,
  input  logic            phaseA,
  input  logic            phaseB,
  input  logic [ROWS-1:0] edgeIn,
  output logic [ROWS-1:0] edgeOut
);
  strobe_t stb;

  seg_mesh_ctrl u_ctrl (
    .cfgShift(cfgShift),
    .phaseA  (phaseA),
    .phaseB  (phaseB),
    .stb     (stb)
  );

  seg_mesh_fabric #(.ROWS(ROWS), .COLS(COLS), .W(W), .P(P)) u_fabric (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .cfgIn  (cfgDin),
    .cfgOut (cfgDout),
    .edgeIn (edgeIn),
    .edgeOut(edgeOut)
  );
endmodule

// File: rtl/seg_mesh_router_chk.sv
module seg_mesh_router_chk #(
  parameter int ROWS = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            cfgShift,
  input logic            phaseA,
  input logic            phaseB,
  input logic            cfgDout,
  input logic [ROWS-1:0] edgeOut
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (edgeOut == '0 && cfgDout == 1'b0)); // R1

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfgShift |=> $stable(cfgDout)); // R2

  AST_SHIFT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    cfgShift |=> $stable(edgeOut)); // R4

  AST_PHASE_ONLY_B: assert property (@(posedge clk) disable iff (rst)
    !(phaseB && !phaseA) |=> $stable(edgeOut)); // R4

  AST_OVERLAP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (phaseA && phaseB) |=> $stable(edgeOut) && $stable(cfgDout)); // R4
endmodule

bind seg_mesh_router seg_mesh_router_chk #(.ROWS(ROWS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfgShift(cfgShift),
  .phaseA  (phaseA),
  .phaseB  (phaseB),
  .cfgDout (cfgDout),
  .edgeOut (edgeOut)
);

// File: tb/seg_mesh_router_bench.sv
`timescale 1ns/1ps
module seg_mesh_router_bench;
  localparam int ROWS = 3, COLS = 2, W = 2, P = 4;
  localparam int NI = 6*W, NO = 3*W, ORB = P*NI, INVB = ORB + NO*P, TB = INVB + NO;
  localparam int N = ROWS*COLS, L = N*TB;

  logic clk = 1'b0, rst = 1'b1, cfgShift = 1'b0, cfgDin = 1'b0;
  logic phaseA = 1'b0, phaseB = 1'b0;
  logic [ROWS-1:0] edgeIn = '0;
  logic cfgDout;
  logic [ROWS-1:0] edgeOut;

  int nRun = 0, nFail = 0;
  bit cmpOn = 1'b0, done = 1'b0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  seg_mesh_router #(.ROWS(ROWS), .COLS(COLS), .W(W), .P(P)) u_seg_mesh_router (
    .clk(clk), .rst(rst), .cfgShift(cfgShift), .cfgDin(cfgDin), .cfgDout(cfgDout),
    .phaseA(phaseA), .phaseB(phaseB), .edgeIn(edgeIn), .edgeOut(edgeOut));

  // ---------------- behavioural reference ----------------
  logic [L-1:0]  mS;
  logic [P-1:0]  mPt [N];
  logic [NO-1:0] mOut [N];
  logic [P-1:0]  nPt [N];
  logic [NO-1:0] nOut [N];
  bit evI, evO, hit;

  function automatic bit mCfg(int t, int idx);
    return mS[(N-1-t)*TB + idx];
  endfunction

  function automatic bit mIn(int r, int c, int i);
    int g = i / W;
    int w = i % W;
    int k = (r % 2 == 0) ? c : c + 1;
    int sr, sc;
    if (g == 4) return mOut[r*COLS+c][2*W+w];
    if (g == 5) return (((r % 2 == 0) ? (c == 0) : (c == COLS-1))) ? edgeIn[r] : 1'b0;
    sr = (g == 0) ? r+1 : (g == 1) ? r+2 : (g == 2) ? r-1 : r-2;
    if (sr < 0 || sr >= ROWS) return 1'b0;
    sc = (sr % 2 == 0) ? k-1 : k;
    if (sc < 0 || sc >= COLS) return 1'b0;
    return (g < 2) ? mOut[sr*COLS+sc][w] : mOut[sr*COLS+sc][W+w];
  endfunction

  function automatic logic [ROWS-1:0] mEdge();
    logic [ROWS-1:0] v;
    for (int r = 0; r < ROWS; r++) begin
      int ec = (r % 2 == 0) ? COLS-1 : 0;
      v[r] = |mOut[r*COLS+ec][2*W-1:W];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mS = '0;
      for (int t = 0; t < N; t++) begin mPt[t] = '0; mOut[t] = '0; end
    end else begin
      evI = phaseA && !phaseB && !cfgShift;
      evO = phaseB && !phaseA && !cfgShift;
      for (int t = 0; t < N; t++) begin nPt[t] = mPt[t]; nOut[t] = mOut[t]; end
      if (evI)
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < COLS; c++)
            for (int p = 0; p < P; p++) begin
              hit = 1'b0;
              for (int i = 0; i < NI; i++)
                if (mCfg(r*COLS+c, p*NI+i) && mIn(r, c, i)) hit = 1'b1;
              nPt[r*COLS+c][p] = !hit;
            end
      if (evO)
        for (int t = 0; t < N; t++)
          for (int o = 0; o < NO; o++) begin
            hit = 1'b0;
            for (int p = 0; p < P; p++)
              if (mCfg(t, ORB+o*P+p) && mPt[t][p]) hit = 1'b1;
            nOut[t][o] = hit ^ mCfg(t, INVB+o);
          end
      for (int t = 0; t < N; t++) begin mPt[t] = nPt[t]; mOut[t] = nOut[t]; end
      if (cfgShift) mS = {cfgDin, mS[L-1:1]};
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (cmpOn && !rst)
      check(edgeOut === mEdge() && cfgDout === mS[0], curReq,
            {edgeOut, cfgDout}, {mEdge(), mS[0]});

  task automatic finishRun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [L-1:0] img, imgA;

  task automatic setBit(input int r, input int c, input int idx);
    img[(N-1-(r*COLS+c))*TB + idx] = 1'b1;
  endtask

  task automatic shiftImage(input logic [L-1:0] v, input bit wiggle);
    cfgShift = 1'b1;
    for (int i = 0; i < L; i++) begin
      cfgDin = v[i];
      phaseA = wiggle && (i % 2 == 0);
      phaseB = wiggle && (i % 2 == 1);
      @(negedge clk);
    end
    cfgShift = 1'b0; phaseA = 1'b0; phaseB = 1'b0;
  endtask

  task automatic period();
    phaseA = 1'b1; phaseB = 1'b0; @(negedge clk);
    phaseA = 1'b0; phaseB = 1'b1; @(negedge clk);
    phaseB = 1'b0;
  endtask

  task automatic randImage();
    for (int i = 0; i < L; i++) img[i] = ($urandom % 4 == 0);
  endtask

  initial begin
    void'($urandom(17));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(edgeOut == '0, "R1 edgeOut after reset", edgeOut, 0);
    check(cfgDout == 1'b0, "R1 cfgDout after reset", cfgDout, 0);
    cmpOn = 1'b1;

    // R2: chain order, length and hold; R1 chain cleared by reset
    curReq = "R2 chain model";
    randImage(); imgA = img;
    cfgShift = 1'b1;
    for (int i = 0; i < L; i++) begin
      check(cfgDout == 1'b0, "R1 cleared chain bit", cfgDout, 0);
      cfgDin = imgA[i]; @(negedge clk);
    end
    randImage();
    for (int i = 0; i < L; i++) begin
      check(cfgDout == imgA[i], "R2 chain emits earlier word in order", cfgDout, imgA[i]);
      cfgDin = img[i]; @(negedge clk);
    end
    cfgShift = 1'b0;
    for (int i = 0; i < 6; i++) begin
      cfgDin = i[0]; @(negedge clk);
      check(cfgDout == img[0], "R2 chain holds with shift low", cfgDout, img[0]);
    end

    // Directed route: rightward row 0, leftward row 1, two-row span to row 2
    curReq = "R5 R6 R8 R9 directed";
    img = '0;
    setBit(0, 0, 0*NI + 5*W + W-1);   setBit(0, 0, ORB + W*P + 0);     setBit(0, 0, INVB + W);
    setBit(1, 0, 0*NI + 2*W);         setBit(1, 0, ORB + W*P + 0);     setBit(1, 0, INVB + W);
    setBit(2, 1, 0*NI + 3*W);         setBit(2, 1, ORB + (W+1)*P + 0); setBit(2, 1, INVB + W+1);
    setBit(1, 1, 0*NI + 5*W);         setBit(1, 1, ORB + 0*P + 0);     setBit(1, 1, INVB + 0);
    setBit(0, 1, 0*NI + 0);           setBit(0, 1, ORB + (W+1)*P + 0); setBit(0, 1, INVB + W+1);
    shiftImage(img, 1'b0);
    edgeIn = '0;
    repeat (3) period();
    check(edgeOut == 3'b000, "R3 settled with inputs low", edgeOut, 3'b000);
    edgeIn = 3'b011;
    period();
    check(edgeOut == 3'b000, "R10 one tile per period, not yet two", edgeOut, 3'b000);
    period();
    check(edgeOut[1] == 1'b1, "R6 row0 rightward then row1 leftward", edgeOut[1], 1);
    check(edgeOut[2] == 1'b1, "R5 down segment spans two rows", edgeOut[2], 1);
    check(edgeOut[0] == 1'b1, "R8 odd-row edge input to R9 row0 output", edgeOut[0], 1);

    // R4: phase patterns with no effect
    curReq = "R4 phase rules";
    edgeIn = '0;
    phaseA = 1'b1; phaseB = 1'b1; repeat (2) @(negedge clk);
    phaseA = 1'b0; phaseB = 1'b0; repeat (2) @(negedge clk);
    check(edgeOut == 3'b111, "R4 overlap or idle phases change nothing", edgeOut, 3'b111);
    phaseA = 1'b1; @(negedge clk); phaseA = 1'b0;
    check(edgeOut == 3'b111, "R4 phase A alone leaves outputs", edgeOut, 3'b111);
    phaseB = 1'b1; @(negedge clk); phaseB = 1'b0;
    check(edgeOut == 3'b111, "R10 second stage still holds old value", edgeOut, 3'b111);
    period();
    check(edgeOut == 3'b000, "R10 low reaches outputs after next period", edgeOut, 3'b000);
    edgeIn = 3'b011; period(); period();

    // Boundary tie and feedback, loaded while phases toggle
    curReq = "R7 R10 boundary and feedback";
    img = '0;
    setBit(0, 1, 0*NI + 2*W);  setBit(0, 1, ORB + W*P + 0);
    setBit(1, 0, 0*NI + 4*W);  setBit(1, 0, ORB + 2*W*P + 0); setBit(1, 0, ORB + W*P + 0);
    shiftImage(img, 1'b1);
    check(edgeOut == 3'b111, "R4 shifting suppresses evaluation", edgeOut, 3'b111);
    edgeIn = '0;
    period();
    check(edgeOut == 3'b011, "R7 missing source reads 0, feedback first", edgeOut, 3'b011);
    period();
    check(edgeOut == 3'b001, "R10 feedback toggles", edgeOut, 3'b001);
    period();
    check(edgeOut == 3'b011, "R10 feedback toggles back", edgeOut, 3'b011);

    // Random programs and traffic against the reference
    for (int k = 0; k < 4; k++) begin
      curReq = "R3 R5 R6 R7 R8 R9 random";
      randImage();
      shiftImage(img, 1'b1);
      for (int n = 0; n < 300; n++) begin
        int sel = $urandom % 10;
        edgeIn = ROWS'($urandom);
        phaseA = (sel < 4) || (sel == 8);
        phaseB = (sel >= 4 && sel < 8) || (sel == 8);
        cfgShift = (sel == 9) && (n % 7 == 0);
        cfgDin = $urandom % 2;
        @(negedge clk);
      end
      cfgShift = 1'b0; phaseA = 1'b0; phaseB = 1'b0;
    end

    @(negedge clk);
    finishRun();
  end
endmodule